// File: doc/BRIEF.md
# Split-Limb Parallel Multiword Multiplier

This block forms the full 512-bit product of two 256-bit unsigned operands. Both operands are cut into sixteen 16-bit limbs. Sixteen multiply-accumulate lanes work in parallel for sixteen cycles on a rotating schedule. Lane `x` in cycle `t` takes A-limb `(t-x) mod 16` and B-limb `15-t`. Before each cycle `t > 0`, the running sum in lane `t` is parked as partial word `31-t` and the lane starts over. When the last cycle ends, the sixteen lane sums are the low partial words. Partial word `k` has weight 2^(16k).

A second phase of sixteen cycles turns the 31 overlapping partial words into sixteen 32-bit product words. Cycle `w` merges four things: the even partial word `2w`, the upper part of the odd word below it, the lower half of the odd word above it (shifted up by 16 bits), and a wide carry from the previous cycle. It then emits product word `w`, least significant first.

A caller pulses `start` with both operands on the input buses. It then collects one product word per cycle while `wordValid` is high. `done` marks the final word.

Top module: `splitLimbMul`

## Requirements
- R1: The sixteen words streamed after a start form the exact 512-bit product of the operands captured at that start. Word `w` holds product bits `32w+31 .. 32w`. Operand bits `16k+15 .. 16k` form limb `k`, so bus word `w` supplies limb `2w` from its low half and limb `2w+1` from its high half.
- R2: A `start` pulse while `busy` is high is ignored. The operation in progress completes with its own operands, and its output stream is unchanged.
- R3: The first product word appears 17 cycles after the cycle in which `start` is accepted. Words then follow on 16 consecutive cycles with `wordIdx` counting 0 to 15.
- R4: `done` is high for exactly one cycle, the cycle that carries product word 15, and at no other time.
- R5: `busy` rises the cycle after a start is accepted and stays high for 32 cycles. It is low in the cycle that shows `done`.
- R6: No lane accumulator ever wraps: each multiply step that adds to a lane leaves it no smaller than before.
- R7: No carry is left over after product word 15 is formed.
- R8: Corner operands give exact results: zero times anything gives zero, and all-ones times all-ones gives the full-width maximum product.
- R9: A start presented in the cycle that shows `done` is accepted, so operations can run back to back with no idle cycle.
- R10: While reset is held, `busy`, `wordValid`, `done`, `wordIdx` and `wordOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; accepted only when not busy |
| aOp | input | 256 | Multiplicand, word 0 at bits 31..0 |
| bOp | input | 256 | Multiplier, word 0 at bits 31..0 |
| busy | output | 1 | Operation in progress |
| wordValid | output | 1 | `wordOut` carries a product word |
| wordIdx | output | 4 | Index of the product word on `wordOut` |
| wordOut | output | 32 | Product word, least significant first |
| done | output | 1 | Final product word is on `wordOut` |

## Verification
Several properties are checked on every cycle by the assertions:
- Lane sums only grow between restarts.
- The carry is empty after the top word.
- `wordIdx` steps by one while words stream.
- `done` appears exactly alongside word 15.
- An accepted start moves the control into the multiply phase.

Other properties can only be shown by the bench's scenarios, which compare against a wide-integer reference product and a cycle count kept in the bench:
- Whether the rotating schedule and the even/odd merge give the right numbers.
- That a start is dropped while busy.
- That a start in the `done` cycle is accepted.
- That corner operands give exact results.

// File: rtl/mulPkg.sv
package mulPkg;
  parameter int LIMB_W  = 16;
  parameter int NLIMB   = 16;
  parameter int ACC_W   = 47;
  localparam int WORD_W  = 2 * LIMB_W;
  localparam int OPND_W  = LIMB_W * NLIMB;
  localparam int IDX_W   = $clog2(NLIMB);
  localparam int NPART   = 2 * NLIMB - 1;
  localparam int NSAVE   = NLIMB - 1;
  localparam int PIDX_W  = $clog2(NPART);
  localparam int CARRY_W = ACC_W - WORD_W;

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_ACC} mulState_t;

  typedef struct packed {
    logic             clr;
    logic             mulEn;
    logic [IDX_W-1:0] tIdx;
    logic             accEn;
    logic [IDX_W-1:0] wIdx;
    logic             lastWord;
  } mulStrobe_t;
endpackage

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mulStrobe_t strobe,
  output logic       busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NLIMB - 1);

  mulState_t        state;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_MUL;
          cnt   <= '0;
        end
        ST_MUL: begin
          if (cnt == LAST) begin
            state <= ST_ACC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACC: begin
          if (cnt == LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clr      = (state == ST_IDLE) && start;
    strobe.mulEn    = (state == ST_MUL);
    strobe.tIdx     = cnt;
    strobe.accEn    = (state == ST_ACC);
    strobe.wIdx     = cnt;
    strobe.lastWord = (state == ST_ACC) && (cnt == LAST);
  end

  assign busy = (state != ST_IDLE);

  // R5: an accepted start enters the multiply phase at step 0
  a_r5_start_enters_mul: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (state == ST_MUL && cnt == '0));

  // R2 / R5: busy is held until the final word is emitted
  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.lastWord) |=> busy);
endmodule

// File: rtl/mulLane.sv
module mulLane
  import mulPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              en,
  input  logic              restart,
  input  logic [LIMB_W-1:0] aLimb,
  input  logic [LIMB_W-1:0] bLimb,
  output logic [ACC_W-1:0]  acc
);
  logic [WORD_W-1:0] prod;

  assign prod = WORD_W'(aLimb) * WORD_W'(bLimb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        acc <= '0;
    else if (clr)     acc <= '0;
    else if (en) begin
      if (restart)    acc <= ACC_W'(prod);
      else            acc <= acc + ACC_W'(prod);
    end
  end

  // R6: a lane sum never wraps between restarts
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (en && !restart && !clr) |=> (acc >= $past(acc)));
endmodule

// File: rtl/mulDatapath.sv
module mulDatapath
  import mulPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mulStrobe_t        strobe,
  input  logic [OPND_W-1:0] aOp,
  input  logic [OPND_W-1:0] bOp,
  output logic              wordValid,
  output logic [IDX_W-1:0]  wordIdx,
  output logic [WORD_W-1:0] wordOut,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NLIMB - 1);

  logic [OPND_W-1:0]  aReg, bReg;
  logic [LIMB_W-1:0]  aLimb [NLIMB];
  logic [LIMB_W-1:0]  bLimb [NLIMB];
  logic [ACC_W-1:0]   laneAcc [NLIMB];
  logic [ACC_W-1:0]   saveSlot [NSAVE];
  logic [ACC_W-1:0]   partArr [NPART];
  logic [CARRY_W-1:0] carry;
  logic [IDX_W-1:0]   bSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
    end else if (strobe.clr) begin
      aReg <= aOp;
      bReg <= bOp;
    end
  end

  assign bSel = LAST - strobe.tIdx;

  for (genvar k = 0; k < NLIMB; k++) begin : gLimb
    assign aLimb[k] = aReg[k*LIMB_W +: LIMB_W];
    assign bLimb[k] = bReg[k*LIMB_W +: LIMB_W];
  end

  for (genvar x = 0; x < NLIMB; x++) begin : gLane
    logic [IDX_W-1:0] aSel;
    logic             laneRestart;
    assign aSel = strobe.tIdx - IDX_W'(x);
    if (x == 0) begin : gFirst
      assign laneRestart = 1'b0;
    end else begin : gRest
      assign laneRestart = strobe.mulEn && (strobe.tIdx == IDX_W'(x));
    end
    mulLane uLane (
      .clk     (clk),
      .rstN    (rstN),
      .clr     (strobe.clr),
      .en      (strobe.mulEn),
      .restart (laneRestart),
      .aLimb   (aLimb[aSel]),
      .bLimb   (bLimb[bSel]),
      .acc     (laneAcc[x])
    );
  end

  for (genvar k = 0; k < NSAVE; k++) begin : gSave
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        saveSlot[k] <= '0;
      else if (strobe.clr)
        saveSlot[k] <= '0;
      else if (strobe.mulEn && (strobe.tIdx == IDX_W'(NSAVE - k)))
        saveSlot[k] <= laneAcc[NSAVE - k];
    end
  end

  for (genvar p = 0; p < NPART; p++) begin : gPart
    if (p < NLIMB) begin : gLow
      assign partArr[p] = laneAcc[NLIMB - 1 - p];
    end else begin : gHigh
      assign partArr[p] = saveSlot[p - NLIMB];
    end
  end

  logic [PIDX_W-1:0] evenIdx, prevIdx, nextIdx;
  logic [ACC_W-1:0]  evenVal, prevHi, nextLo, sum;

  always_comb begin
    evenIdx = {strobe.wIdx, 1'b0};
    prevIdx = (strobe.wIdx == '0)  ? evenIdx : evenIdx - 1'b1;
    nextIdx = (strobe.wIdx == LAST) ? evenIdx : evenIdx + 1'b1;
    evenVal = partArr[evenIdx];
    prevHi  = (strobe.wIdx == '0) ? '0 : (partArr[prevIdx] >> LIMB_W);
    nextLo  = (strobe.wIdx == LAST) ? '0
            : ACC_W'({partArr[nextIdx][LIMB_W-1:0], LIMB_W'(0)});
    sum     = evenVal + prevHi + nextLo + ACC_W'(carry);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carry     <= '0;
      wordValid <= 1'b0;
      wordIdx   <= '0;
      wordOut   <= '0;
      done      <= 1'b0;
    end else begin
      wordValid <= strobe.accEn;
      done      <= strobe.lastWord;
      if (strobe.clr) begin
        carry <= '0;
      end else if (strobe.accEn) begin
        carry   <= sum[ACC_W-1:WORD_W];
        wordOut <= sum[WORD_W-1:0];
        wordIdx <= strobe.wIdx;
      end
    end
  end

  // R7: nothing is left in the carry once the top word is out
  a_r7_no_final_carry: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (carry == '0));

  // R4: done marks word 15 and only word 15
  a_r4_done_on_last: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (wordValid && wordIdx == LAST));
  a_r4_last_has_done: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordIdx == LAST) |-> done);

  // R3: words stream on consecutive cycles in ascending order
  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordIdx != LAST) |=> (wordValid && wordIdx == $past(wordIdx) + 1'b1));
endmodule

// File: rtl/splitLimbMul.sv
module splitLimbMul
  import mulPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OPND_W-1:0] aOp,
  input  logic [OPND_W-1:0] bOp,
  output logic              busy,
  output logic              wordValid,
  output logic [IDX_W-1:0]  wordIdx,
  output logic [WORD_W-1:0] wordOut,
  output logic              done
);
  mulStrobe_t strobe;

  mulCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy)
  );

  mulDatapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .aOp       (aOp),
    .bOp       (bOp),
    .wordValid (wordValid),
    .wordIdx   (wordIdx),
    .wordOut   (wordOut),
    .done      (done)
  );
endmodule

// File: tb/tb_splitLimbMul.sv
module tb_splitLimbMul;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [255:0] aOp = '0;
  logic [255:0] bOp = '0;
  logic         busy, wordValid, done;
  logic [3:0]   wordIdx;
  logic [31:0]  wordOut;

  int errors = 0;
  int checks = 0;
  int n = -1;
  bit finished = 1'b0;
  logic [511:0] expProd = '0;
  string curTag = "R1";
  string opTag = "R1";

  always #10 clk = ~clk;

  splitLimbMul dut (
    .clk(clk), .rstN(rstN), .start(start), .aOp(aOp), .bOp(bOp),
    .busy(busy), .wordValid(wordValid), .wordIdx(wordIdx),
    .wordOut(wordOut), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit st, input logic [255:0] a, input logic [255:0] b);
    bit idle;
    bit expValid;
    int idx;
    start = st; aOp = a; bOp = b;
    idle = (n < 0) || (n >= 32);
    @(posedge clk);
    if (st && idle) begin
      n = 0;
      expProd = 512'(a) * 512'(b);
      opTag = curTag;
    end else if (n >= 0 && n < 64) begin
      n++;
    end
    @(negedge clk);
    start = 1'b0;
    expValid = (n >= 17) && (n <= 32);
    check(wordValid == expValid, "R3 wordValid", 512'(wordValid), 512'(expValid));
    check(done == (n == 32), "R4 done", 512'(done), 512'(n == 32));
    check(busy == (n >= 0 && n <= 31), "R5 busy", 512'(busy), 512'(n >= 0 && n <= 31));
    if (expValid) begin
      idx = n - 17;
      check(wordIdx == 4'(idx), "R3 wordIdx", 512'(wordIdx), 512'(idx));
      check(wordOut == expProd[idx*32 +: 32], {opTag, " wordOut"},
            512'(wordOut), 512'(expProd[idx*32 +: 32]));
    end
  endtask

  task automatic runOp(input logic [255:0] a, input logic [255:0] b, input string tag);
    curTag = tag;
    step(1'b1, a, b);
    while (n < 32) step(1'b0, '0, '0);
  endtask

  initial begin
    logic [255:0] ones;
    ones = '1;
    // R10: reset state
    repeat (3) @(negedge clk);
    check(!busy && !wordValid && !done, "R10 flags", 512'({busy, wordValid, done}), 512'(0));
    check(wordIdx == 4'd0 && wordOut == 32'd0, "R10 data", 512'({wordIdx, wordOut}), 512'(0));
    rstN = 1'b1;
    step(1'b0, '0, '0);

    runOp(256'd3, 256'd5, "R1");
    step(1'b0, '0, '0);
    for (int i = 0; i < 3; i++) begin
      runOp(rnd256(), rnd256(), "R1");
      step(1'b0, '0, '0);
    end
    // limb routing: single limbs in distinct positions
    runOp(256'h1 << 48, 256'hbeef << 208, "R1");
    step(1'b0, '0, '0);

    // R8 corners, all-ones also exercises R6 / R7
    runOp('0, rnd256(), "R8");
    runOp(ones, ones, "R8/R6/R7");
    runOp(ones, 256'd1, "R8");
    step(1'b0, '0, '0);

    // R2: start while busy is ignored
    curTag = "R2";
    step(1'b1, rnd256(), rnd256());
    for (int i = 0; i < 9; i++) step(1'b0, '0, '0);
    step(1'b1, ones, ones);
    step(1'b1, 256'd7, 256'd9);
    while (n < 32) step(1'b0, '0, '0);

    // R9: back-to-back start in the done cycle
    runOp(rnd256(), rnd256(), "R9");
    runOp(rnd256(), rnd256(), "R9");
    runOp(ones, rnd256(), "R9");
    repeat (3) step(1'b0, '0, '0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule